// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block merges five reset requests into one system reset and remembers which of them fired. The sources are a power-on request from the supply monitor, an active-low external reset pin, a watchdog expiry line, a brown-out comparator output and a reset command from the debug port. Every request except power-on passes through a two-flop synchronizer. The pin request and the brown-out request then pass through a minimum-width filter, so that short glitches do nothing.

The system reset rises in the same cycle as a qualified request. Power-on asserts it asynchronously. Once the last request has gone, the reset is held for a start-up delay counted in ticks of a 1 MHz timebase. A fuse input picks one of two lengths, 4100 ticks (4.1 ms) or 65000 ticks (65 ms). The release always happens on a clock edge.

A five-bit sticky cause register records which sources have fired. Software clears a flag by writing 0 to it. Brown-out detection only works when its enable fuse input is high.

Top module: `reset_cause_ctrl`

## Requirements
- R1: Any qualified request from any of the five sources drives `sys_rst_o` high. The watchdog and debug requests need only be high for one clock edge after synchronization. Flag bit positions are: bit 0 power-on, bit 1 external pin, bit 2 brown-out, bit 3 watchdog, bit 4 debug.
- R2: The external pin is a request only when it has been sampled low, after synchronization, on at least `EXT_MIN_CYC` consecutive clock edges. A shorter low pulse causes no reset and leaves its flag unchanged.
- R3: A brown-out indication is a request only when it lasts longer than `BOD_MIN_CYC` edges, that is `BOD_MIN_CYC+1` consecutive edges. A pulse of exactly `BOD_MIN_CYC` edges is ignored.
- R4: While `bod_en_i` is low, the brown-out input has no effect on `sys_rst_o` or on the flags.
- R5: Release timing after the last request drops:
  - The hold counts only cycles in which `tick_i` is high.
  - `sys_rst_o` falls `DLY_SHORT` ticks after counting starts when `dly_long_i` is 0, and `DLY_LONG` ticks after when it is 1.
  - For the watchdog and debug requests, counting starts on the 3rd edge after the input drops. For filtered requests, it starts on the 4th edge.
- R6: `sys_rst_o` rises in the same cycle as a filtered request. For a pin held low from a negative edge, it is high after edge `2+EXT_MIN_CYC`. A new request arriving during the hold restarts the delay from that request's removal.
- R7: Power-on behaviour:
  - While `por_i` is high, `sys_rst_o` is 1 and the flags read 5'b00001. Both take effect asynchronously, without waiting for a clock.
  - After `por_i` falls, the hold lasts the selected delay counted from the first edge.
- R8: A flag is set when its source causes a reset. Flags are sticky and accumulate across different sources until software clears them or power-on resets them.
- R9: A write with `wr_en_i` high clears every flag whose `wr_data_i` bit is 0. Writing 1 to a bit has no effect, so a cleared flag stays cleared.
- R10: When a source's request is active in the same cycle as a write that clears its flag, the flag stays set. The other flags are cleared as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| bod_low_i | input | 1 | Brown-out comparator output, high when the supply is low |
| dbg_rst_i | input | 1 | Debug-port reset command |
| bod_en_i | input | 1 | Fuse: enables brown-out detection |
| tick_i | input | 1 | 1 MHz timebase tick, one clock wide |
| dly_long_i | input | 1 | Fuse: 0 selects the short delay, 1 the long delay |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 5 | Write data; a 0 bit clears the matching flag |
| sys_rst_o | output | 1 | System reset, active high |
| cause_o | output | 5 | Sticky cause flags |

## Verification
Two functions can land on the same clock edge: a software clear of the cause register and a source setting its flag. The bench provokes this by holding the debug request active for several cycles and writing all-zero data in the middle of it. It then judges that the debug flag survives while the watchdog flag, set earlier, is cleared. A related overlap, a new request arriving while the release counter is running, is checked by measuring that the hold restarts from the second request's removal.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   localparam int unsigned NUM_SRC = 5;

   typedef enum logic [2:0] {
      SRC_POR = 3'd0,
      SRC_EXT = 3'd1,
      SRC_BOD = 3'd2,
      SRC_WDT = 3'd3,
      SRC_DBG = 3'd4
   } src_e;

   typedef logic [NUM_SRC-1:0] cause_t;

   function automatic cause_t cause_bit(src_e s);
      return cause_t'(1) << s;
   endfunction

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rcc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rcc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rcc_min_width.sv
module rcc_min_width #(
   parameter int unsigned MIN_CYC = 75,
   parameter bit          STRICT  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic in_i,
   output logic out_o
);

   if (MIN_CYC < 1) begin : g_bad_min
      $error("rcc_min_width: MIN_CYC must be at least 1");
   end

   localparam int unsigned THR = STRICT ? MIN_CYC + 1 : MIN_CYC;
   localparam int unsigned CW  = $clog2(THR + 1);

   logic [CW-1:0] cnt_q;
   logic          out_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!in_i) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!out_q) begin
         if (cnt_q == CW'(THR - 1)) out_q <= 1'b1;
         else                       cnt_q <= cnt_q + 1'b1;
      end
   end

   assign out_o = out_q;

   // R2 / R3: a qualified output needs the input present on the previous edge
   p_filter_qual_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      out_q |-> $past(in_i));

   // R3: losing the input drops the qualified request on the next edge
   p_filter_drop_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !in_i |=> !out_q);

endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int unsigned DLY_SHORT = 4100,
   parameter int unsigned DLY_LONG  = 65000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic req_i,
   input  logic tick_i,
   input  logic sel_long_i,
   output logic rst_o
);

   if (DLY_SHORT < 1 || DLY_LONG < DLY_SHORT) begin : g_bad_dly
      $error("rcc_stretch: need 1 <= DLY_SHORT <= DLY_LONG");
   end

   localparam int unsigned CW = $clog2(DLY_LONG + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic          hold_q;

   assign lim = sel_long_i ? CW'(DLY_LONG - 1) : CW'(DLY_SHORT - 1);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (req_i) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (hold_q && tick_i) begin
         if (cnt_q >= lim) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign rst_o = rst_i | req_i | hold_q;

   // R5: release happens only on a tick edge with no request pending
   p_release_on_tick_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(hold_q) |-> ($past(tick_i) && !$past(req_i)));

   // R6: any request rearms the hold for the next cycle
   p_retrigger_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      req_i |=> hold_q);

endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
   import rcc_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   input  cause_t set_i,
   input  logic   wr_en_i,
   input  cause_t wr_data_i,
   output cause_t flags_o
);

   cause_t flags_q;
   cause_t keep_mask;

   assign keep_mask = wr_en_i ? wr_data_i : '1;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) flags_q <= cause_bit(SRC_POR);
      else       flags_q <= (flags_q & keep_mask) | set_i;
   end

   assign flags_o = flags_q;

   // R10: a source active in a cycle always leaves its flag set
   p_set_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

   // R9: a write with no concurrent source leaves only written-1 bits
   p_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && set_i == '0) |=> ((flags_q & ~$past(wr_data_i)) == '0));

   // R8: with no write and no source the flags are sticky
   p_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!wr_en_i && set_i == '0) |=> $stable(flags_q));

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
   import rcc_pkg::*;
#(
   parameter int unsigned EXT_MIN_CYC = 75,
   parameter int unsigned BOD_MIN_CYC = 100,
   parameter int unsigned DLY_SHORT   = 4100,
   parameter int unsigned DLY_LONG    = 65000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       ext_rst_n_i,
   input  logic       wdt_expire_i,
   input  logic       bod_low_i,
   input  logic       dbg_rst_i,
   input  logic       bod_en_i,
   input  logic       tick_i,
   input  logic       dly_long_i,
   input  logic       wr_en_i,
   input  logic [4:0] wr_data_i,
   output logic       sys_rst_o,
   output logic [4:0] cause_o
);

   if (NUM_SRC != 5) begin : g_bad_src
      $error("reset_cause_ctrl: port widths assume five sources");
   end

   localparam int unsigned NUM_ASYNC = NUM_SRC - 1;

   logic [NUM_ASYNC-1:0] raw_req;
   logic [NUM_ASYNC-1:0] sync_req;
   cause_t               qual_req;
   logic                 any_req;

   // index i of raw_req belongs to source i+1
   assign raw_req[SRC_EXT-1] = ~ext_rst_n_i;
   assign raw_req[SRC_BOD-1] = bod_low_i & bod_en_i;
   assign raw_req[SRC_WDT-1] = wdt_expire_i;
   assign raw_req[SRC_DBG-1] = dbg_rst_i;

   rcc_sync #(
      .WIDTH  (NUM_ASYNC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_i (por_i),
      .d_i   (raw_req),
      .q_o   (sync_req)
   );

   assign qual_req[SRC_POR] = 1'b0;

   for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_EXT) begin : g_pin_filter
         rcc_min_width #(
            .MIN_CYC (EXT_MIN_CYC),
            .STRICT  (1'b0)
         ) u_flt (
            .clk_i (clk_i),
            .rst_i (por_i),
            .in_i  (sync_req[i-1]),
            .out_o (qual_req[i])
         );
      end else if (i == SRC_BOD) begin : g_bod_filter
         rcc_min_width #(
            .MIN_CYC (BOD_MIN_CYC),
            .STRICT  (1'b1)
         ) u_flt (
            .clk_i (clk_i),
            .rst_i (por_i),
            .in_i  (sync_req[i-1]),
            .out_o (qual_req[i])
         );
      end else begin : g_direct
         assign qual_req[i] = sync_req[i-1];
      end
   end

   assign any_req = |qual_req;

   rcc_stretch #(
      .DLY_SHORT (DLY_SHORT),
      .DLY_LONG  (DLY_LONG)
   ) u_stretch (
      .clk_i      (clk_i),
      .rst_i      (por_i),
      .req_i      (any_req),
      .tick_i     (tick_i),
      .sel_long_i (dly_long_i),
      .rst_o      (sys_rst_o)
   );

   rcc_cause_reg u_cause (
      .clk_i     (clk_i),
      .rst_i     (por_i),
      .set_i     (qual_req),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .flags_o   (cause_o)
   );

   // R1: a qualified request from any source shows in the system reset
   p_any_source_r1: assert property (@(posedge clk_i) disable iff (por_i)
      any_req |-> sys_rst_o);

   // R7: the power-on flag is never raised again outside power-on
   p_por_flag_r7: assert property (@(posedge clk_i) disable iff (por_i)
      !cause_o[SRC_POR] |=> !cause_o[SRC_POR]);

endmodule

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;

   localparam int EXT_MIN = 6;
   localparam int BOD_MIN = 8;
   localparam int DSHORT  = 41;
   localparam int DLONG   = 650;

   logic       clk = 1'b0;
   logic       por_i = 1'b1;
   logic       ext_rst_n_i = 1'b1;
   logic       wdt_expire_i = 1'b0;
   logic       bod_low_i = 1'b0;
   logic       dbg_rst_i = 1'b0;
   logic       bod_en_i = 1'b1;
   logic       tick_i = 1'b1;
   logic       dly_long_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [4:0] wr_data_i = 5'b0;
   logic       sys_rst_o;
   logic [4:0] cause_o;
   logic       tick_gap = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   always @(negedge clk) tick_i <= tick_gap ? ~tick_i : 1'b1;

   reset_cause_ctrl #(
      .EXT_MIN_CYC (EXT_MIN),
      .BOD_MIN_CYC (BOD_MIN),
      .DLY_SHORT   (DSHORT),
      .DLY_LONG    (DLONG)
   ) uut (
      .clk_i        (clk),
      .por_i        (por_i),
      .ext_rst_n_i  (ext_rst_n_i),
      .wdt_expire_i (wdt_expire_i),
      .bod_low_i    (bod_low_i),
      .dbg_rst_i    (dbg_rst_i),
      .bod_en_i     (bod_en_i),
      .tick_i       (tick_i),
      .dly_long_i   (dly_long_i),
      .wr_en_i      (wr_en_i),
      .wr_data_i    (wr_data_i),
      .sys_rst_o    (sys_rst_o),
      .cause_o      (cause_o)
   );

   // src: 1 pin, 2 brown-out, 3 watchdog, 4 debug (also the flag bit)
   typedef struct packed {
      logic [2:0] src;
      logic [7:0] len;
      logic       bod_en;
      logic       exp_rst;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{3'd1, 8'd5,  1'b1, 1'b0},   // R2 one short of the minimum
      '{3'd1, 8'd6,  1'b1, 1'b1},   // R2 exactly the minimum
      '{3'd1, 8'd2,  1'b1, 1'b0},   // R2 glitch
      '{3'd2, 8'd8,  1'b1, 1'b0},   // R3 equal to the limit, ignored
      '{3'd2, 8'd9,  1'b1, 1'b1},   // R3 longer than the limit
      '{3'd2, 8'd30, 1'b0, 1'b0},   // R4 detection disabled
      '{3'd3, 8'd1,  1'b1, 1'b1},   // R1 watchdog single edge
      '{3'd4, 8'd1,  1'b1, 1'b1},   // R1 debug single edge
      '{3'd4, 8'd3,  1'b1, 1'b1},   // R1 debug several edges
      '{3'd1, 8'd20, 1'b1, 1'b1}    // R2 long pin hold
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive_src(input int s, input bit v);
      case (s)
         1: ext_rst_n_i  = ~v;
         2: bod_low_i    = v;
         3: wdt_expire_i = v;
         default: dbg_rst_i = v;
      endcase
   endtask

   task automatic write_flags(input logic [4:0] d);
      @(negedge clk);
      wr_en_i = 1'b1;
      wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // counts negative edges until sys_rst_o equals lvl
   task automatic wait_level(input bit lvl, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (sys_rst_o != lvl && n < 5000);
   endtask

   task automatic pulse(input int s, input int len);
      @(negedge clk);
      drive_src(s, 1'b1);
      repeat (len) @(negedge clk);
      drive_src(s, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      bit seen;

      // R7 reset state and power-on release
      repeat (3) @(negedge clk);
      chk(sys_rst_o == 1'b1, "R7 reset held during power-on", sys_rst_o, 1);
      chk(cause_o == 5'b00001, "R7 power-on flag", cause_o, 1);
      por_i = 1'b0;
      wait_level(1'b0, n);
      chk(n == DSHORT, "R7 power-on release delay", n, DSHORT);
      chk(cause_o == 5'b00001, "R7 flags after release", cause_o, 1);

      // table walk over sources and filter boundaries
      foreach (VEC[i]) begin
         bod_en_i = VEC[i].bod_en;
         write_flags(5'b00000);
         seen = 1'b0;
         @(negedge clk);
         drive_src(int'(VEC[i].src), 1'b1);
         for (int k = 0; k < int'(VEC[i].len); k++) begin
            @(negedge clk);
            if (sys_rst_o) seen = 1'b1;
         end
         drive_src(int'(VEC[i].src), 1'b0);
         for (int k = 0; k < DSHORT + 10; k++) begin
            @(negedge clk);
            if (sys_rst_o) seen = 1'b1;
         end
         chk(seen == VEC[i].exp_rst,
             VEC[i].src == 3'd1 ? "R2 pin reset" :
             VEC[i].src == 3'd2 ? (VEC[i].bod_en ? "R3 brown-out reset" : "R4 brown-out disabled")
                                : "R1 direct source reset",
             seen, VEC[i].exp_rst);
         chk(cause_o == (VEC[i].exp_rst ? (5'b1 << VEC[i].src) : 5'b0),
             VEC[i].src == 3'd2 && !VEC[i].bod_en ? "R4 flags untouched" : "R8 cause flag",
             cause_o, VEC[i].exp_rst ? (1 << VEC[i].src) : 0);
         chk(sys_rst_o == 1'b0, "R5 released after vector", sys_rst_o, 0);
      end
      bod_en_i = 1'b1;

      // R6 assertion latency and R5 release latency for a filtered source
      write_flags(5'b00000);
      @(negedge clk);
      ext_rst_n_i = 1'b0;
      wait_level(1'b1, n);
      chk(n == 2 + EXT_MIN, "R6 pin assertion latency", n, 2 + EXT_MIN);
      repeat (2) @(negedge clk);
      ext_rst_n_i = 1'b1;
      wait_level(1'b0, n);
      chk(n == 3 + DSHORT, "R5 short delay after pin", n, 3 + DSHORT);

      // R5 long delay via watchdog
      dly_long_i = 1'b1;
      pulse(3, 2);
      wait_level(1'b0, n);
      chk(n == 2 + DLONG, "R5 long delay after watchdog", n, 2 + DLONG);
      dly_long_i = 1'b0;

      // R5 delay counts ticks only
      tick_gap = 1'b1;
      pulse(4, 2);
      wait_level(1'b0, n);
      chk(n >= 2 * DSHORT && n <= 2 * DSHORT + 4, "R5 tick gating", n, 2 * DSHORT + 2);
      tick_gap = 1'b0;
      repeat (2) @(negedge clk);

      // R6 retrigger during the hold
      pulse(1, 8);
      repeat (20) @(negedge clk);
      chk(sys_rst_o == 1'b1, "R6 still holding", sys_rst_o, 1);
      pulse(4, 2);
      wait_level(1'b0, n);
      chk(n == 2 + DSHORT, "R6 hold restarted", n, 2 + DSHORT);

      // R8 accumulation, R9 clear semantics
      write_flags(5'b00000);
      chk(cause_o == 5'b00000, "R9 clear all", cause_o, 0);
      pulse(1, 8);
      wait_level(1'b0, n);
      pulse(3, 2);
      wait_level(1'b0, n);
      chk(cause_o == 5'b01010, "R8 flags accumulate", cause_o, 10);
      write_flags(5'b11101);
      chk(cause_o == 5'b01000, "R9 ones do not set", cause_o, 8);

      // R10 source and clear in the same cycle
      @(negedge clk);
      dbg_rst_i = 1'b1;
      repeat (4) @(negedge clk);
      write_flags(5'b00000);
      chk(cause_o == 5'b10000, "R10 set wins over clear", cause_o, 16);
      dbg_rst_i = 1'b0;
      wait_level(1'b0, n);
      chk(cause_o == 5'b10000, "R10 flag kept after release", cause_o, 16);

      // R7 asynchronous power-on mid-run
      @(negedge clk);
      #3 por_i = 1'b1;
      #1;
      chk(cause_o == 5'b00001, "R7 async flag reset", cause_o, 1);
      chk(sys_rst_o == 1'b1, "R7 async reset assertion", sys_rst_o, 1);
      @(negedge clk);
      por_i = 1'b0;
      wait_level(1'b0, n);
      chk(n == DSHORT, "R7 release after second power-on", n, DSHORT);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule